// File: doc/BRIEF.md
# Bypassable DC-Blocking High-Pass Filter

This block sits directly behind a 10-bit converter and strips the DC component from its sample stream. Each sample arrives with a valid strobe and feeds a first-order recursive high-pass section. The pole of that section lies just inside the unit circle, so the −3 dB corner falls at roughly one four-hundredth of the sample rate. The arithmetic is fixed-point. Quantised coefficients and a feedback state carry extra fraction bits below the output LSB. Every result is clamped to the 10-bit signed range and never wraps.

Two level controls shape the output. The first is a bypass control. It routes the incoming sample straight to the output in the same clock and skips the filter's one-clock delay. The recursion keeps running on every valid sample while bypassed, so dropping bypass later resumes from a settled state and produces no startup transient. The second control picks the output code: two's complement, or straight binary formed by flipping only the sign bit.

Top module: `dc_block_hpf`

## Requirements
- R1: Input and output samples are 10-bit two's complement. 0x1FF is the largest value, 0x000 is zero, 0x3FF is −1 and 0x200 is the most negative value. In bypass these codes reach the output unchanged.
- R2: On each valid non-bypassed-or-bypassed sample x, the state s (8 fraction bits, clamped to ±2^19) becomes rnd(64531·s / 2^16) + rnd(65532·(x − x_prev) / 2^8), where rnd rounds half up. The filtered output is rnd(s / 2^8) clamped to [−512, 511].
- R3: With bypass low, valid_o is high exactly one clock after a valid input sample, and the filtered result appears in that same clock.
- R4: With bypass high, valid_o equals valid_i and data_o equals data_i (after format) in the same clock, with no register between them.
- R5: With fmt_bin_i high, data_o is the two's complement result with only bit 9 inverted.
- R6: A result above 511 gives 0x1FF and a result below −512 gives 0x200. A full-scale positive step from a settled −512 input gives 0x1FF, and the reverse step gives 0x200.
- R7: While rst_ni is low, valid_o is low and the state, previous input and filtered output are zero.
- R8: The state and previous input update on every valid sample while bypassed. The first filtered output after bypass drops equals the value that continuous filtering would give.
- R9: For a constant input held for 2000 valid samples, the filtered output settles to exactly 0x000.
- R10: A cycle with valid_i low leaves the state and the filtered output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| data_i | input | 10 | Input sample, two's complement |
| bypass_i | input | 1 | 1 = pass input straight through |
| fmt_bin_i | input | 1 | 1 = straight binary output (bit 9 inverted) |
| valid_o | output | 1 | Output sample strobe |
| data_o | output | 10 | Output sample |

## Verification
The bench builds the block with its default parameters: 10 data bits, 16 coefficient fraction bits, 8 guard bits and 2 headroom bits. These values put the settled DC deadband below half an output LSB, so the exact zero of R9 can be checked. The two headroom bits let a full-scale step overshoot inside the state while the output saturates, so both clamp codes of R6 can be reached with a single step from a settled rail. A bit-exact model of the same recursion allows a comparison in every cycle across random data, gaps in the valid strobe, and random toggling of both controls.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  localparam int unsigned DCB_DATA_W  = 10;
  localparam int unsigned DCB_FRAC_W  = 16;
  localparam int unsigned DCB_GUARD_W = 8;
  localparam int unsigned DCB_HEAD_W  = 2;
  // pole ~0.98466, gain ~0.99994, both in Q16
  localparam int          DCB_P_COEF  = 64531;
  localparam int          DCB_K_COEF  = 65532;

  typedef enum logic {
    FMT_TWOS   = 1'b0,
    FMT_OFFSET = 1'b1
  } out_fmt_e;
endpackage

// File: rtl/dcb_delta.sv
module dcb_delta #(
  parameter int unsigned DATA_W = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic        [DATA_W-1:0] data_i,
  output logic signed [DATA_W:0]   diff_o
);
  logic [DATA_W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prev_q <= '0;
    else if (valid_i) prev_q <= data_i;
  end

  assign diff_o = $signed({data_i[DATA_W-1], data_i}) - $signed({prev_q[DATA_W-1], prev_q});
endmodule

// File: rtl/dcb_iir_core.sv
module dcb_iir_core #(
  parameter int unsigned DATA_W  = 10,
  parameter int unsigned FRAC_W  = 16,
  parameter int unsigned GUARD_W = 8,
  parameter int unsigned HEAD_W  = 2,
  parameter int          P_COEF  = 64531,
  parameter int          K_COEF  = 65532,
  localparam int unsigned STATE_W = DATA_W + HEAD_W + GUARD_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic signed [DATA_W:0]    diff_i,
  output logic signed [STATE_W-1:0] state_d_o
);
  localparam int unsigned COEF_W = FRAC_W + 2;
  localparam int unsigned DIFF_W = DATA_W + 1;
  localparam int unsigned FB_W   = STATE_W + COEF_W;
  localparam int unsigned FF_W   = DIFF_W + COEF_W;
  localparam int unsigned SH     = FRAC_W - GUARD_W;
  localparam int unsigned SUM_W  = FB_W + 1;

  localparam logic signed [COEF_W-1:0] P_S     = COEF_W'(P_COEF);
  localparam logic signed [COEF_W-1:0] K_S     = COEF_W'(K_COEF);
  localparam logic signed [FB_W-1:0]   FB_HALF = FB_W'(64'sd1 <<< (FRAC_W - 1));
  localparam logic signed [SUM_W-1:0]  S_MAX   = SUM_W'((64'sd1 <<< (STATE_W - 1)) - 64'sd1);
  localparam logic signed [SUM_W-1:0]  S_MIN   = SUM_W'(-(64'sd1 <<< (STATE_W - 1)));

  logic signed [STATE_W-1:0] state_q;
  logic signed [FB_W-1:0]    fb_prod, fb_rnd;
  logic signed [FF_W-1:0]    ff_prod, ff_rnd;
  logic signed [SUM_W-1:0]   sum, sum_sat;

  assign fb_prod = FB_W'(state_q) * FB_W'(P_S);
  assign fb_rnd  = (fb_prod + FB_HALF) >>> FRAC_W;
  assign ff_prod = FF_W'(diff_i) * FF_W'(K_S);

  generate
    if (SH > 0) begin : g_ff_round
      localparam logic signed [FF_W-1:0] FF_HALF = FF_W'(64'sd1 <<< (SH - 1));
      assign ff_rnd = (ff_prod + FF_HALF) >>> SH;
    end else begin : g_ff_exact
      assign ff_rnd = ff_prod;
    end
  endgenerate

  assign sum = SUM_W'(fb_rnd) + SUM_W'(ff_rnd);

  always_comb begin
    if (sum > S_MAX)      sum_sat = S_MAX;
    else if (sum < S_MIN) sum_sat = S_MIN;
    else                  sum_sat = sum;
  end

  assign state_d_o = STATE_W'(sum_sat);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= '0;
    else if (valid_i) state_q <= state_d_o;
  end
endmodule

// File: rtl/dcb_round_sat.sv
module dcb_round_sat #(
  parameter int unsigned DATA_W  = 10,
  parameter int unsigned GUARD_W = 8,
  parameter int unsigned STATE_W = 20
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic                      fvalid_i,
  input  logic signed [STATE_W-1:0] state_d_i,
  output logic        [DATA_W-1:0]  filt_o,
  output logic                      fvalid_o
);
  localparam int unsigned RW = STATE_W + 1;
  localparam logic signed [RW-1:0] O_MAX = RW'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam logic signed [RW-1:0] O_MIN = RW'(-(64'sd1 <<< (DATA_W - 1)));

  logic signed [RW-1:0] ext, rnd;
  logic [DATA_W-1:0]    sat;

  assign ext = RW'(state_d_i);

  generate
    if (GUARD_W > 0) begin : g_round
      localparam logic signed [RW-1:0] HALF = RW'(64'sd1 <<< (GUARD_W - 1));
      assign rnd = (ext + HALF) >>> GUARD_W;
    end else begin : g_none
      assign rnd = ext;
    end
  endgenerate

  always_comb begin
    if (rnd > O_MAX)      sat = DATA_W'(O_MAX);
    else if (rnd < O_MIN) sat = DATA_W'(O_MIN);
    else                  sat = DATA_W'(rnd);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_o   <= '0;
      fvalid_o <= 1'b0;
    end else begin
      if (load_i) filt_o <= sat;
      fvalid_o <= fvalid_i;
    end
  end
endmodule

// File: rtl/dcb_out_fmt.sv
module dcb_out_fmt
  import dcb_pkg::*;
#(
  parameter int unsigned DATA_W = 10
) (
  input  logic              bypass_i,
  input  out_fmt_e          fmt_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              fvalid_i,
  input  logic [DATA_W-1:0] filt_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] sel;

  assign sel     = bypass_i ? data_i : filt_i;
  assign valid_o = bypass_i ? valid_i : fvalid_i;
  assign data_o  = sel ^ {(fmt_i == FMT_OFFSET), {(DATA_W-1){1'b0}}};
endmodule

// File: rtl/dc_block_hpf.sv
module dc_block_hpf
  import dcb_pkg::*;
#(
  parameter int unsigned DATA_W  = DCB_DATA_W,
  parameter int unsigned FRAC_W  = DCB_FRAC_W,
  parameter int unsigned GUARD_W = DCB_GUARD_W,
  parameter int unsigned HEAD_W  = DCB_HEAD_W,
  parameter int          P_COEF  = DCB_P_COEF,
  parameter int          K_COEF  = DCB_K_COEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bypass_i,
  input  logic              fmt_bin_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned STATE_W = DATA_W + HEAD_W + GUARD_W;

  logic signed [DATA_W:0]    diff;
  logic signed [STATE_W-1:0] state_d;
  logic [DATA_W-1:0]         filt;
  logic                      fvalid;
  out_fmt_e                  fmt;

  assign fmt = out_fmt_e'(fmt_bin_i);

  dcb_delta #(.DATA_W(DATA_W)) i_delta (
    .clk_i, .rst_ni, .valid_i, .data_i, .diff_o(diff)
  );

  dcb_iir_core #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W), .GUARD_W(GUARD_W), .HEAD_W(HEAD_W),
    .P_COEF(P_COEF), .K_COEF(K_COEF)
  ) i_core (
    .clk_i, .rst_ni, .valid_i, .diff_i(diff), .state_d_o(state_d)
  );

  // state and filtered register advance in bypass too; only the strobe is gated
  dcb_round_sat #(.DATA_W(DATA_W), .GUARD_W(GUARD_W), .STATE_W(STATE_W)) i_rsat (
    .clk_i, .rst_ni, .load_i(valid_i), .fvalid_i(valid_i & ~bypass_i),
    .state_d_i(state_d), .filt_o(filt), .fvalid_o(fvalid)
  );

  dcb_out_fmt #(.DATA_W(DATA_W)) i_fmt (
    .bypass_i, .fmt_i(fmt), .valid_i, .data_i, .fvalid_i(fvalid), .filt_i(filt),
    .valid_o, .data_o
  );
endmodule

// File: rtl/dcb_checker.sv
module dcb_checker #(
  parameter int unsigned DATA_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] data_i,
  input logic              bypass_i,
  input logic              fmt_bin_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] data_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r3_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    !bypass_i |-> valid_o == $past(valid_i & ~bypass_i));

  a_r4_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |-> (valid_o == valid_i) &&
                 ((data_o ^ {fmt_bin_i, {(DATA_W-1){1'b0}}}) == data_i));

  a_r7_reset_quiet: assert property (@(posedge clk_i)
    (!rst_ni && !bypass_i) |-> !valid_o);

  a_r10_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    (!bypass_i && !$past(bypass_i) && !$past(valid_i) && $stable(fmt_bin_i)) |-> $stable(data_o));
endmodule

bind dc_block_hpf dcb_checker #(.DATA_W(DATA_W)) i_dcb_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
  .bypass_i(bypass_i), .fmt_bin_i(fmt_bin_i), .valid_o(valid_o), .data_o(data_o)
);

// File: tb/test_dc_block_hpf.sv
module test_dc_block_hpf;
  localparam int DW = 10;
  localparam longint P = 64531;
  localparam longint K = 65532;
  localparam longint SMAX = (64'sd1 <<< 19) - 1;
  localparam longint SMIN = -(64'sd1 <<< 19);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0, bypass_i = 1'b0, fmt_bin_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic valid_o;
  logic [DW-1:0] data_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  longint m_state = 0, m_xprev = 0, m_fout = 0;
  bit m_fvalid = 1'b0;

  always #2 clk = ~clk;

  dc_block_hpf i_dc_block_hpf (
    .clk_i(clk), .rst_ni, .valid_i, .data_i, .bypass_i, .fmt_bin_i, .valid_o, .data_o
  );

  function automatic longint rshr(longint v, int n);
    return (v + (64'sd1 <<< (n - 1))) >>> n;
  endfunction

  function automatic longint clampl(longint v, longint lo, longint hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    done = 1'b1;
    $finish;
  endtask

  // one sample period: drive, compare against model, advance model
  task automatic step(int x, bit v, bit byp, bit fmt, string tag = "");
    bit ev;
    logic [DW-1:0] ed;
    longint ns;
    string t;
    @(negedge clk);
    valid_i = v; data_i = DW'(x); bypass_i = byp; fmt_bin_i = fmt;
    #1;
    ev = byp ? v : m_fvalid;
    ed = DW'(byp ? longint'(x) : m_fout) ^ {fmt, {(DW-1){1'b0}}};
    t = (tag != "") ? tag : (byp ? "R4" : (!v ? "R10" : "R2"));
    if (fmt) t = {t, " R5"};
    chk(valid_o == ev, {t, " valid"}, valid_o, ev);
    chk(data_o == ed, {t, " data"}, data_o, ed);
    if (v) begin
      ns = clampl(rshr(P * m_state, 16) + rshr(K * (longint'(x) - m_xprev), 8), SMIN, SMAX);
      m_state = ns;
      m_xprev = x;
      m_fout = clampl(rshr(ns, 8), -512, 511);
    end
    m_fvalid = v && !byp;
  endtask

  function automatic int rnd_x();
    return int'($urandom_range(0, 1023)) - 512;
  endfunction

  initial begin
    int cnt;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R7: quiet while reset held
    chk(valid_o == 1'b0, "R7 valid in reset", valid_o, 0);
    chk(data_o == '0, "R7 data in reset", data_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    #1;
    chk(valid_o == 1'b0, "R7 valid after reset", valid_o, 0);

    // R3: strobe appears one clock after the sample, not in it
    step(100, 1, 0, 0, "R3");
    chk(valid_o == 1'b0, "R3 same-cycle strobe", valid_o, 0);
    step(0, 0, 0, 0, "R3");
    chk(valid_o == 1'b1, "R3 next-cycle strobe", valid_o, 1);

    // R1: code points pass unchanged in bypass
    step(511, 1, 1, 0, "R1");
    chk(data_o == 10'h1FF, "R1 max code", data_o, 10'h1FF);
    step(-1, 1, 1, 0, "R1");
    chk(data_o == 10'h3FF, "R1 minus one", data_o, 10'h3FF);
    step(-512, 1, 1, 1, "R1");
    chk(data_o == 10'h000, "R5 min code as binary", data_o, 10'h000);

    // random filtered stream with valid gaps and format changes
    for (int i = 0; i < 3000; i++)
      step(rnd_x(), ($urandom_range(0, 3) != 0), 0, ($urandom_range(0, 7) == 0));

    // R6: full-scale positive step from settled minimum
    for (int i = 0; i < 1500; i++) step(-512, 1, 0, 0);
    step(511, 1, 0, 0, "R6");
    step(511, 1, 0, 0, "R6");
    chk(data_o == 10'h1FF, "R6 positive clamp", data_o, 10'h1FF);
    for (int i = 0; i < 1500; i++) step(511, 1, 0, 0);
    step(-512, 1, 0, 0, "R6");
    step(-512, 1, 0, 0, "R6");
    chk(data_o == 10'h200, "R6 negative clamp", data_o, 10'h200);

    // R8: random bypass toggling; filtered cycles after bypass checked by model
    cnt = 0;
    for (int i = 0; i < 2000; i++) begin
      bit b;
      b = ($urandom_range(0, 3) == 0) ? ~bypass_i : bypass_i;
      if (!b && bypass_i) cnt++;
      step(rnd_x(), ($urandom_range(0, 4) != 0), b, ($urandom_range(0, 5) == 0),
           (!b && bypass_i) ? "R8" : "");
    end
    chk(cnt > 0, "R8 bypass exits seen", cnt, 1);

    // R9: DC input settles to zero
    for (int i = 0; i < 2000; i++) step(300, 1, 0, 0);
    step(300, 1, 0, 0, "R9");
    chk(data_o == 10'h000, "R9 settled DC", data_o, 0);
    chk(valid_o == 1'b1, "R9 settled valid", valid_o, 1);

    // R10: idle cycles leave output untouched
    for (int i = 0; i < 5; i++) step(rnd_x(), 0, 0, 0, "R10");
    chk(data_o == 10'h000, "R10 held output", data_o, 0);

    finish_run();
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        chk(1'b0, "watchdog", cyc, 150000);
        finish_run();
      end
    end
  end
endmodule